// File: doc/BRIEF.md
# Transmit Start and Collision Retry Controller

This block decides when an outgoing frame may begin and replays it after a collision. Software supplies a buffer page and a 16-bit byte count, split into a low byte and a high byte, then pulses a go command. The count covers the addresses, the type/length field and the payload. Preamble and CRC belong to the transmitter and are not counted. On the command the block clears its status, latches the setup and waits while a reception is in progress. It then reads the frame byte by byte from buffer memory into a small FIFO. The address starts at page × 256 and increases by one per byte.

The transmitter is told to start only when three things hold at once: the medium has been free of carrier for a programmable gap time, the FIFO holds at least one byte, and any collision backoff has ended. The end of backoff arrives as a pulse from outside. If carrier appears while the FIFO is still empty, the block gives the medium to the receiver and rearms. On every collision the FIFO is flushed, the read address and count are restored, and the attempt is counted. The sixteenth collision aborts the frame. Software must program a nonzero byte count.

Top module: `tx_start_retry`

## Requirements
- R1: After reset, cmd_busy, st_done, st_col, st_abort, irq, tx_start, tx_valid and mem_rd are 0, and col_count is 0.
- R2: A cmd_go pulse while idle sets cmd_busy in the next cycle and clears st_done, st_col, st_abort and col_count.
- R3: While rx_busy is high after a command, no buffer read (mem_rd) is issued.
- R4: The frame bytes come out on tx_data in order. They are read from addresses page×256 + 0 through page×256 + count − 1, with count = {reg_cnt_hi, reg_cnt_lo}. A byte is consumed in a cycle where tx_valid and tx_ready are high and collision is low.
- R5: tx_start is not raised until at least IFG cycles (GAP_PS / CLK_PS, 640 by default) of carrier-free medium have passed since reset or since carrier last fell. When the FIFO is ready, it is raised within 8 cycles after that.
- R6: If carrier is high in the first prefetch cycle, while the FIFO is still empty, the block defers. It issues no reads while carrier stays high, and it later sends the whole frame from its first byte.
- R7: A collision while sending sets st_col and increments col_count. The frame is then resent from its first byte.
- R8: After a collision, tx_start and tx_valid stay low until a backoff_done pulse arrives.
- R9: The 16th collision of a frame sets st_abort, clears cmd_busy, leaves st_done at 0 and makes col_count read 0.
- R10: When the last byte is consumed, st_done is set, cmd_busy clears and irq pulses for exactly one cycle. An abort also gives exactly one irq pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_page | input | 8 | Buffer page holding the frame |
| reg_cnt_lo | input | 8 | Byte count, low byte |
| reg_cnt_hi | input | 8 | Byte count, high byte |
| cmd_go | input | 1 | Transmit request pulse |
| rx_busy | input | 1 | Reception in progress |
| carrier | input | 1 | Carrier sensed on the medium |
| collision | input | 1 | Collision reported during sending |
| backoff_done | input | 1 | Pulse marking the end of collision backoff |
| mem_rd | output | 1 | Buffer read strobe |
| mem_addr | output | 16 | Buffer read address |
| mem_data | input | 8 | Read data, valid in the strobe cycle |
| tx_start | output | 1 | One-cycle start pulse to the transmitter |
| tx_valid | output | 1 | A byte is offered on tx_data |
| tx_data | output | 8 | Frame byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| cmd_busy | output | 1 | Command bit; self-clears on done or abort |
| st_done | output | 1 | Frame sent successfully |
| st_col | output | 1 | At least one collision in this frame |
| st_abort | output | 1 | Frame dropped after excessive collisions |
| col_count | output | 4 | Collisions seen for this frame |
| irq | output | 1 | One-cycle interrupt strobe |

## Verification
The hardest state to reach from the ports is the sixteenth collision. Getting there takes fifteen full cycles of start, partial send, collision and backoff release, all without a stray completion. The bench loops over these rounds: it waits for each start pulse, lets two bytes go, raises collision, re-queues the whole frame in the scoreboard and releases backoff. The deferral path is almost as narrow, because carrier has to rise in exactly the first prefetch cycle. The bench counts edges from the command pulse to hit that cycle.

// File: rtl/tsr_pkg.sv
// Shared types for the transmit start / retry controller.
package tsr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no command pending
        ST_ARM  = 2'd1,   // command held, waiting for a free receiver and medium
        ST_FILL = 2'd2,   // prefetching, waiting for the start conditions
        ST_SEND = 2'd3    // transmitter consuming bytes
    } tx_state_t;
endpackage

// File: rtl/tsr_gap_timer.sv
// Gap timer: counts carrier-free cycles up to GAP_CYC and then holds.
// Assumes carrier is synchronous to clk. Any carrier cycle restarts the count.
module tsr_gap_timer #(
    parameter int GAP_CYC = 640
) (
    input  logic clk,
    input  logic rst_n,
    input  logic carrier,
    output logic gap_ok
);
    localparam int CW = $clog2(GAP_CYC + 1);

    logic [CW-1:0] cnt;

    // Restart on carrier, otherwise count up and saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || carrier) cnt <= '0;
        else if (cnt != CW'(GAP_CYC)) cnt <= cnt + 1'b1;
    end

    assign gap_ok = (cnt == CW'(GAP_CYC));
endmodule

// File: rtl/tsr_fifo.sv
// Prefetch FIFO: single clock, first-word fall-through, flush has priority.
// Assumes DEPTH is a power of two and at least 2.
module tsr_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign dout  = mem[rp[AW-1:0]];

    // Pointer update; a flush empties the FIFO in one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) wp <= wp + 1'b1;
            if (pop && !empty) rp <= rp + 1'b1;
        end
    end

    // Storage write, suppressed during a flush.
    always_ff @(posedge clk) begin
        if (push && !full && !flush) mem[wp[AW-1:0]] <= din;
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) (push && !flush) |-> !full);   // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (pop && !flush) |-> !empty);   // R4
endmodule

// File: rtl/tsr_dma.sv
// Buffer reader: walks the buffer from page*256 for cnt_in bytes while run is high.
// A load restores the start address and the full count, and beats a read in the same cycle.
module tsr_dma #(
    parameter int PAGE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [PAGE_W-1:0]   page,
    input  logic [CNT_W-1:0]    cnt_in,
    input  logic                run,
    input  logic                fifo_full,
    output logic                mem_rd,
    output logic [PAGE_W+7:0]   mem_addr
);
    localparam int ADDR_W = PAGE_W + 8;

    logic [ADDR_W-1:0] ptr;
    logic [CNT_W-1:0]  rem;

    assign mem_rd   = run && !load && (rem != '0) && !fifo_full;
    assign mem_addr = ptr;

    // Restore on load, otherwise advance one byte per read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            rem <= '0;
        end else if (load) begin
            ptr <= {page, 8'h00};
            rem <= cnt_in;
        end else if (mem_rd) begin
            ptr <= ptr + 1'b1;
            rem <= rem - 1'b1;
        end
    end

    AST_RESTORE_COUNT: assert property (@(posedge clk) disable iff (!rst_n) load |=> (rem == $past(cnt_in)));   // R7
endmodule

// File: rtl/tx_start_retry.sv
// Transmit start and collision retry controller.
// Latches the buffer page and byte count on cmd_go, prefetches the frame and starts the
// transmitter once gap, FIFO and backoff conditions all hold. Replays the frame on each
// collision and aborts on the MAX_COL-th. Assumes a nonzero byte count and a mem_data
// that is valid in the mem_rd cycle.
module tx_start_retry #(
    parameter int PAGE_W     = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int CLK_PS     = 10000,
    parameter int GAP_PS     = 6400000,
    parameter int MAX_COL    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PAGE_W-1:0]    reg_page,
    input  logic [7:0]           reg_cnt_lo,
    input  logic [7:0]           reg_cnt_hi,
    input  logic                 cmd_go,
    input  logic                 rx_busy,
    input  logic                 carrier,
    input  logic                 collision,
    input  logic                 backoff_done,
    output logic                 mem_rd,
    output logic [PAGE_W+7:0]    mem_addr,
    input  logic [7:0]           mem_data,
    output logic                 tx_start,
    output logic                 tx_valid,
    output logic [7:0]           tx_data,
    input  logic                 tx_ready,
    output logic                 cmd_busy,
    output logic                 st_done,
    output logic                 st_col,
    output logic                 st_abort,
    output logic [$clog2(MAX_COL)-1:0] col_count,
    output logic                 irq
);
    import tsr_pkg::*;

    localparam int GAP_CYC = GAP_PS / CLK_PS;
    localparam int CW      = $clog2(MAX_COL);

    tx_state_t        state;
    logic [PAGE_W-1:0] page_q;
    logic [15:0]      total_q;
    logic [15:0]      sent;
    logic             bo_wait;
    logic             gap_ok, f_empty, f_full;
    logic             pop, start_ok, defer, col_evt, last, dma_load, dma_run, abort_now;

    assign tx_valid  = (state == ST_SEND) && !f_empty;
    assign pop       = tx_valid && tx_ready && !collision;
    assign start_ok  = (state == ST_FILL) && gap_ok && !f_empty && !bo_wait;
    assign defer     = (state == ST_FILL) && carrier && f_empty;
    assign col_evt   = (state == ST_SEND) && collision;
    assign abort_now = col_evt && (col_count == CW'(MAX_COL - 1));
    assign last      = pop && (sent == total_q - 16'd1);
    assign dma_load  = ((state == ST_ARM) && !rx_busy && !carrier) || defer || col_evt;
    assign dma_run   = (state == ST_FILL) || (state == ST_SEND);

    tsr_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk(clk), .rst_n(rst_n), .carrier(carrier), .gap_ok(gap_ok)
    );

    tsr_dma #(.PAGE_W(PAGE_W), .CNT_W(16)) u_dma (
        .clk(clk), .rst_n(rst_n), .load(dma_load), .page(page_q), .cnt_in(total_q),
        .run(dma_run), .fifo_full(f_full), .mem_rd(mem_rd), .mem_addr(mem_addr)
    );

    tsr_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(dma_load), .push(mem_rd), .din(mem_data),
        .pop(pop), .dout(tx_data), .empty(f_empty), .full(f_full)
    );

    // Sequencing of command, prefetch, start, retry and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            page_q    <= '0;
            total_q   <= '0;
            sent      <= '0;
            bo_wait   <= 1'b0;
            tx_start  <= 1'b0;
            irq       <= 1'b0;
            cmd_busy  <= 1'b0;
            st_done   <= 1'b0;
            st_col    <= 1'b0;
            st_abort  <= 1'b0;
            col_count <= '0;
        end else begin
            tx_start <= 1'b0;
            irq      <= 1'b0;
            if (backoff_done) bo_wait <= 1'b0;
            case (state)
                ST_IDLE: if (cmd_go) begin
                    page_q    <= reg_page;
                    total_q   <= {reg_cnt_hi, reg_cnt_lo};
                    cmd_busy  <= 1'b1;
                    st_done   <= 1'b0;
                    st_col    <= 1'b0;
                    st_abort  <= 1'b0;
                    col_count <= '0;
                    bo_wait   <= 1'b0;
                    state     <= ST_ARM;
                end
                ST_ARM: if (!rx_busy && !carrier) begin
                    sent  <= '0;
                    state <= ST_FILL;
                end
                ST_FILL: begin
                    if (defer) state <= ST_ARM;
                    else if (start_ok) begin
                        tx_start <= 1'b1;
                        state    <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (col_evt) begin
                        st_col <= 1'b1;
                        sent   <= '0;
                        if (abort_now) begin
                            st_abort  <= 1'b1;
                            col_count <= '0;
                            cmd_busy  <= 1'b0;
                            irq       <= 1'b1;
                            state     <= ST_IDLE;
                        end else begin
                            col_count <= col_count + 1'b1;
                            bo_wait   <= 1'b1;
                            state     <= ST_FILL;
                        end
                    end else if (last) begin
                        st_done  <= 1'b1;
                        cmd_busy <= 1'b0;
                        irq      <= 1'b1;
                        state    <= ST_IDLE;
                    end else if (pop) begin
                        sent <= sent + 16'd1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_START_AFTER_GAP:     assert property (@(posedge clk) disable iff (!rst_n) tx_start |-> $past(gap_ok));    // R5
    AST_START_AFTER_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n) tx_start |-> !$past(bo_wait));  // R8
    AST_ABORT_COUNT_ZERO:    assert property (@(posedge clk) disable iff (!rst_n) st_abort |-> (col_count == '0)); // R9
    AST_IRQ_ONE_CYCLE:       assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);                  // R10
    AST_DONE_NOT_ABORT:      assert property (@(posedge clk) disable iff (!rst_n) !(st_done && st_abort));        // R9
endmodule

// File: tb/tb_tx_start_retry.sv
module tb_tx_start_retry;
    localparam int GAP = 640;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_page = '0, reg_cnt_lo = '0, reg_cnt_hi = '0;
    logic        cmd_go = 1'b0, rx_busy = 1'b0, carrier = 1'b0, collision = 1'b0, backoff_done = 1'b0;
    logic        tx_ready = 1'b1;
    logic        stall_mode = 1'b0;
    logic        mem_rd, tx_start, tx_valid, cmd_busy, st_done, st_col, st_abort, irq;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data, tx_data;
    logic [3:0]  col_count;

    int checks = 0, failures = 0;
    int cyc = 0, rd_cnt = 0, tv_cnt = 0, start_cnt = 0, irq_cnt = 0;
    logic [7:0] exp_q[$];
    bit done_flag = 1'b0;

    tx_start_retry dut (
        .clk(clk), .rst_n(rst_n), .reg_page(reg_page), .reg_cnt_lo(reg_cnt_lo), .reg_cnt_hi(reg_cnt_hi),
        .cmd_go(cmd_go), .rx_busy(rx_busy), .carrier(carrier), .collision(collision),
        .backoff_done(backoff_done), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .tx_start(tx_start), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .cmd_busy(cmd_busy), .st_done(st_done), .st_col(st_col), .st_abort(st_abort),
        .col_count(col_count), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction
    assign mem_data = mem_fn(mem_addr);

    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) tx_ready <= stall_mode ? (cyc % 3 != 0) : 1'b1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard for every byte the transmitter takes.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) rd_cnt++;
            if (tx_valid) tv_cnt++;
            if (tx_start) start_cnt++;
            if (irq) irq_cnt++;
            if (tx_valid && tx_ready && !collision) begin
                if (exp_q.size() == 0) chk("R4 unexpected byte", {24'h0, tx_data}, 32'hFFFF);
                else chk("R4 byte order", {24'h0, tx_data}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // Driver: queue the expected frame bytes.
    task automatic push_frame(input logic [7:0] page, input int len);
        for (int i = 0; i < len; i++) exp_q.push_back(mem_fn({page, 8'h00} + 16'(i)));
    endtask

    task automatic issue(input logic [7:0] page, input int len);
        reg_page = page; reg_cnt_lo = 8'(len); reg_cnt_hi = 8'(len >> 8);
        push_frame(page, len);
        cmd_go = 1'b1; tick(1); cmd_go = 1'b0;
    endtask

    task automatic wait_start();
        int n = 0;
        while (!tx_start && n < 5000) begin tick(1); n++; end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (cmd_busy && n < 5000) begin tick(1); n++; end
    endtask

    task automatic bump_collision(input logic [7:0] page, input int len);
        collision = 1'b1; tick(1); collision = 1'b0;
        exp_q.delete();
        push_frame(page, len);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog actual=%0d expected=<150000", cyc);
        finish_run();
    end

    initial begin
        int c0, n0, r0, t0, s0, i0;
        tick(3);
        // R1 reset state
        chk("R1 cmd_busy", cmd_busy, 0); chk("R1 st_done", st_done, 0);
        chk("R1 st_col", st_col, 0);     chk("R1 st_abort", st_abort, 0);
        chk("R1 col_count", col_count, 0); chk("R1 irq", irq, 0);
        chk("R1 tx_valid", tx_valid, 0); chk("R1 mem_rd", mem_rd, 0);
        chk("R1 tx_start", tx_start, 0);
        rst_n = 1'b1; c0 = cyc;

        // A: first frame must wait out the gap from reset (R5), then complete (R10)
        i0 = irq_cnt;
        issue(8'h12, 20);
        chk("R2 busy after command", cmd_busy, 1);
        wait_start();
        chk("R5 gap from reset lower", (cyc - c0) >= GAP, 1);
        chk("R5 gap from reset upper", (cyc - c0) <= GAP + 8, 1);
        wait_idle(); tick(2);
        chk("R10 done", st_done, 1); chk("R10 no abort", st_abort, 0);
        chk("R10 one irq", irq_cnt - i0, 1); chk("R4 frame drained", exp_q.size(), 0);

        // B: receiver busy holds off prefetch (R3), status cleared by command (R2)
        rx_busy = 1'b1; stall_mode = 1'b1;
        issue(8'h03, 5);
        chk("R2 done cleared", st_done, 0);
        r0 = rd_cnt; tick(30);
        chk("R3 no reads while rx_busy", rd_cnt - r0, 0);
        rx_busy = 1'b0;
        wait_idle(); tick(2); stall_mode = 1'b0;
        chk("R10 done after stalls", st_done, 1); chk("R4 frame drained B", exp_q.size(), 0);

        // C: carrier in the first prefetch cycle defers (R6); gap restarts at carrier fall (R5)
        reg_page = 8'h05; reg_cnt_lo = 8'd10; reg_cnt_hi = 8'd0; push_frame(8'h05, 10);
        cmd_go = 1'b1; tick(1); cmd_go = 1'b0;
        tick(1); carrier = 1'b1;
        tick(1); r0 = rd_cnt; t0 = tv_cnt;
        tick(40);
        chk("R6 no reads under carrier", rd_cnt - r0, 0);
        chk("R6 nothing offered under carrier", tv_cnt - t0, 0);
        carrier = 1'b0; c0 = cyc;
        wait_start();
        chk("R5 gap after carrier lower", (cyc - c0) >= GAP, 1);
        chk("R5 gap after carrier upper", (cyc - c0) <= GAP + 8, 1);
        wait_idle(); tick(2);
        chk("R6 done after defer", st_done, 1); chk("R6 whole frame once", exp_q.size(), 0);

        // D: one collision, replay from first byte (R7), held until backoff ends (R8)
        issue(8'h07, 12);
        wait_start(); tick(4);
        bump_collision(8'h07, 12);
        chk("R7 col bit", st_col, 1); chk("R7 count one", col_count, 1);
        t0 = tv_cnt; s0 = start_cnt; tick(60);
        chk("R8 no offer in backoff", tv_cnt - t0, 0);
        chk("R8 no start in backoff", start_cnt - s0, 0);
        backoff_done = 1'b1; tick(1); backoff_done = 1'b0;
        wait_start(); wait_idle(); tick(2);
        chk("R7 done after retry", st_done, 1); chk("R7 count kept", col_count, 1);
        chk("R7 replay drained", exp_q.size(), 0);

        // E: sixteen collisions abort (R9)
        i0 = irq_cnt;
        issue(8'h09, 6);
        for (int k = 1; k <= 16; k++) begin
            wait_start(); tick(2);
            bump_collision(8'h09, 6);
            if (k < 16) begin
                chk("R7 count step", col_count, k);
                backoff_done = 1'b1; tick(1); backoff_done = 1'b0;
            end
        end
        tick(1);
        chk("R9 abort", st_abort, 1); chk("R9 count reads zero", col_count, 0);
        chk("R9 busy cleared", cmd_busy, 0); chk("R9 no done", st_done, 0);
        chk("R10 one irq on abort", irq_cnt - i0, 1);
        n0 = tv_cnt; tick(20);
        chk("R9 nothing after abort", tv_cnt - n0, 0);
        exp_q.delete();
        finish_run();
    end
endmodule